// File: doc/BRIEF.md
# Partitioned Double-Buffered Endpoint Packet Buffer

This block holds the packet storage for a set of USB endpoints in one 4096-byte RAM. Endpoint 0 always owns the 64 bytes at the bottom of the RAM, runs single-buffered and has a 64-byte packet limit. Every other endpoint receives its region through a configuration strobe. The strobe carries a start address, a region size, a packet limit and a flag that selects single or double buffering. A request is range-checked, and the block accepts it only when every check passes.

A producer appends bytes to an endpoint and then commits the packet, which raises a one-cycle packet-done pulse on that endpoint's bit. A consumer reads the committed bytes in order and then releases the half it has drained. In double-buffered mode the region is split into two equal halves that are filled and drained alternately. This lets one half fill while the other is being read. Overflow, underflow, stall and traffic to an unconfigured endpoint are each handled at the ports.

Top module: `ep_packet_buffer`

## Requirements
- R1: After reset, epFull, pktDone, overflow, underflow, reject, cfgAck and rdData are all zero. Endpoint 0 is the only endpoint that accepts traffic.
- R2: Endpoint 0 is fixed: 64 bytes at address 0, single-buffered, 64-byte packet limit. A configuration request for endpoint 0 is refused with cfgErr bit 4 set.
- R3: One cycle after cfgWr, cfgAck pulses and cfgErr reports the checks. cfgErr is zero when the request is accepted. Bit 0 is set when the size is below the packet limit (or below twice the limit when double-buffered), or when the limit is outside 1..64. Bit 1 is set when the region overlaps endpoint 0 or another configured region. Bit 2 is set when base+size exceeds 4096. Bit 3 is set when the base is not a multiple of 8. A refused request leaves the endpoint's previous setup unchanged.
- R4: A write, commit, read or release aimed at an unconfigured endpoint pulses reject for one cycle and changes no state.
- R5: Each accepted write appends one byte to the fill half. An accepted commit marks that half full and pulses pktDone on the endpoint's bit in the next cycle.
- R6: epFull is set once every half of an endpoint is full. This happens after one commit in single-buffered mode and after two in double-buffered mode.
- R7: While epFull is set, writes and commits to that endpoint are ignored. Nothing is stored and no pktDone pulse is raised.
- R8: Bytes written past the packet limit are dropped and set that endpoint's sticky overflow bit.
- R9: rdData presents the next byte of the drain half one cycle after rdEn, in the order written. rdLen combinationally shows the byte count of the drain half of rdEp, or zero when that half is empty.
- R10: A read with no unread byte in the drain half returns zero and sets that endpoint's sticky underflow bit.
- R11: A release frees the drain half and clears epFull. In double-buffered mode it moves draining to the other half.
- R12: An accepted configuration request clears that endpoint's buffer contents, full state and sticky flags.
- R13: Traffic on one endpoint never changes data stored for another endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration request strobe |
| cfgEp | input | 2 | Endpoint being configured |
| cfgBase | input | 12 | Region start byte address |
| cfgSize | input | 13 | Region size in bytes |
| cfgMaxPkt | input | 7 | Packet limit in bytes |
| cfgDouble | input | 1 | 1 selects double buffering |
| cfgAck | output | 1 | Result valid, one cycle after cfgWr |
| cfgErr | output | 5 | Check result, zero means accepted |
| wrEn | input | 1 | Append wrData to endpoint wrEp |
| wrCommit | input | 1 | Commit the fill half of wrEp (a write in the same cycle is dropped) |
| wrEp | input | 2 | Producer endpoint |
| wrData | input | 8 | Byte to append |
| rdEn | input | 1 | Read the next byte of rdEp |
| rdRelease | input | 1 | Release the drain half of rdEp (a read in the same cycle is dropped) |
| rdEp | input | 2 | Consumer endpoint |
| rdData | output | 8 | Byte read, one cycle after rdEn |
| rdLen | output | 7 | Byte count of the drain half of rdEp |
| epFull | output | 4 | Per endpoint: all halves full |
| pktDone | output | 4 | Per endpoint: one-cycle packet-commit pulse |
| overflow | output | 4 | Per endpoint sticky overflow |
| underflow | output | 4 | Per endpoint sticky underflow |
| reject | output | 1 | Pulse: traffic to an unconfigured endpoint |

## Verification
The bench drives configuration requests that each trip exactly one region check. These include a base inside endpoint 0, a region that ends exactly where a neighbour begins, and a packet limit of 0 and of 65. A design with an off-by-one overlap or range compare would refuse a legal layout or accept an illegal one. A 64-byte packet is followed by a 65th byte, a byte written into a stalled endpoint, and a read past the packet end. A design that mishandled these would corrupt the next packet's length, count the dropped byte or return stale data instead of zero. Releasing a double-buffered endpoint must deliver the second packet, and a reconfiguration must clear its flags. A wrong half pointer or a missed clear shows up in the expected bytes and flags.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  localparam int unsigned RamBytes    = 4096;
  localparam int unsigned Ep0Bytes    = 64;
  localparam int unsigned MaxPktLimit = 64;
  localparam int unsigned DataW       = 8;
  localparam int unsigned AlignBits   = 3;
  localparam int unsigned AddrW       = $clog2(RamBytes);
  localparam int unsigned SizeW       = AddrW + 1;
  localparam int unsigned CntW        = $clog2(MaxPktLimit) + 1;
  localparam int unsigned ErrW        = 5;

  // bit order is visible at the cfgErr port
  typedef struct packed {
    logic fixedEp;
    logic misaligned;
    logic outOfRange;
    logic overlap;
    logic tooSmall;
  } cfg_err_t;

  typedef struct packed {
    logic             wrStb;
    logic [AddrW-1:0] wrAddr;
    logic [DataW-1:0] wrByte;
    logic             rdStb;
    logic [AddrW-1:0] rdAddr;
  } dp_strobe_t;
endpackage

// File: rtl/epbuf_slot.sv
module epbuf_slot
  import epbuf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  input  logic [CntW-1:0] maxPkt,
  input  logic            dbl,
  input  logic            wrReq,
  input  logic            commitReq,
  input  logic            rdReq,
  input  logic            releaseReq,
  output logic            fillHalf,
  output logic            drainHalf,
  output logic [CntW-1:0] fillCnt,
  output logic [CntW-1:0] rdPtr,
  output logic [CntW-1:0] drainLen,
  output logic            wrOk,
  output logic            rdOk,
  output logic            full,
  output logic            overflow,
  output logic            underflow,
  output logic            pktDone
);
  logic [1:0]      halfFull;
  logic [CntW-1:0] cnt [2];
  logic            fillQ, drainQ;
  logic [CntW-1:0] ptrQ;

  assign fillHalf  = fillQ;
  assign drainHalf = drainQ;
  assign rdPtr     = ptrQ;
  assign full      = halfFull[fillQ];
  assign fillCnt   = cnt[fillQ];
  assign drainLen  = halfFull[drainQ] ? cnt[drainQ] : '0;
  assign wrOk      = wrReq && !full && (cnt[fillQ] < maxPkt);
  assign rdOk      = rdReq && (ptrQ < drainLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfFull  <= '0;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      fillQ     <= 1'b0;
      drainQ    <= 1'b0;
      ptrQ      <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      pktDone   <= 1'b0;
    end else if (clr) begin
      halfFull  <= '0;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      fillQ     <= 1'b0;
      drainQ    <= 1'b0;
      ptrQ      <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      pktDone   <= 1'b0;
    end else begin
      pktDone <= 1'b0;
      // producer side touches only the fill half, which is never full here
      if (wrReq && !full) begin
        if (cnt[fillQ] < maxPkt) cnt[fillQ] <= cnt[fillQ] + 1'b1;
        else                     overflow   <= 1'b1;
      end
      if (commitReq && !full) begin
        halfFull[fillQ] <= 1'b1;
        pktDone         <= 1'b1;
        if (dbl) fillQ <= ~fillQ;
      end
      // consumer side touches only the drain half, which is full when used
      if (rdReq) begin
        if (rdOk) ptrQ      <= ptrQ + 1'b1;
        else      underflow <= 1'b1;
      end
      if (releaseReq && halfFull[drainQ]) begin
        halfFull[drainQ] <= 1'b0;
        cnt[drainQ]      <= '0;
        ptrQ             <= '0;
        if (dbl) drainQ <= ~drainQ;
      end
    end
  end
endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned EpW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [EpW-1:0]    cfgEp,
  input  logic [AddrW-1:0]  cfgBase,
  input  logic [SizeW-1:0]  cfgSize,
  input  logic [CntW-1:0]   cfgMaxPkt,
  input  logic              cfgDouble,
  output logic              cfgAck,
  output logic [ErrW-1:0]   cfgErr,
  input  logic              wrEn,
  input  logic              wrCommit,
  input  logic [EpW-1:0]    wrEp,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  input  logic              rdRelease,
  input  logic [EpW-1:0]    rdEp,
  output logic [CntW-1:0]   rdLen,
  output logic [NUM_EP-1:0] epFull,
  output logic [NUM_EP-1:0] pktDone,
  output logic [NUM_EP-1:0] overflow,
  output logic [NUM_EP-1:0] underflow,
  output logic              reject,
  output dp_strobe_t        stb
);
  localparam int unsigned EndW = SizeW + 1;

  logic [AddrW-1:0]  epBase [NUM_EP];
  logic [SizeW-1:0]  epSize [NUM_EP];
  logic [CntW-1:0]   epMax  [NUM_EP];
  logic [NUM_EP-1:0] epDbl, epOn;

  cfg_err_t        chk;
  logic            cfgOk;
  logic [EndW-1:0] endNew;
  logic [CntW:0]   need;

  // region checks on the incoming request
  always_comb begin
    chk    = '0;
    endNew = EndW'(cfgBase) + EndW'(cfgSize);
    need   = cfgDouble ? {cfgMaxPkt, 1'b0} : {1'b0, cfgMaxPkt};
    chk.fixedEp    = (cfgEp == '0) || (32'(cfgEp) >= NUM_EP);
    chk.misaligned = cfgBase[AlignBits-1:0] != '0;
    chk.outOfRange = endNew > EndW'(RamBytes);
    chk.tooSmall   = (cfgMaxPkt == '0) || (cfgMaxPkt > CntW'(MaxPktLimit)) ||
                     (cfgSize < SizeW'(need));
    chk.overlap    = cfgBase < AddrW'(Ep0Bytes);
    for (int j = 1; j < NUM_EP; j++) begin
      if (epOn[j] && (EpW'(j) != cfgEp) &&
          (EndW'(cfgBase) < EndW'(epBase[j]) + EndW'(epSize[j])) &&
          (EndW'(epBase[j]) < endNew))
        chk.overlap = 1'b1;
    end
  end
  assign cfgOk = (chk == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAck <= 1'b0;
      cfgErr <= '0;
      epDbl  <= '0;
      epOn   <= NUM_EP'(1);
      for (int e = 0; e < NUM_EP; e++) begin
        epBase[e] <= '0;
        epSize[e] <= (e == 0) ? SizeW'(Ep0Bytes) : '0;
        epMax[e]  <= (e == 0) ? CntW'(MaxPktLimit) : '0;
      end
    end else begin
      cfgAck <= cfgWr;
      if (cfgWr) cfgErr <= chk;
      if (cfgWr && cfgOk) begin
        epBase[cfgEp] <= cfgBase;
        epSize[cfgEp] <= cfgSize;
        epMax[cfgEp]  <= cfgMaxPkt;
        epDbl[cfgEp]  <= cfgDouble;
        epOn[cfgEp]   <= 1'b1;
      end
    end
  end

  logic wrOn, rdOn;
  assign wrOn = epOn[wrEp];
  assign rdOn = epOn[rdEp];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reject <= 1'b0;
    else       reject <= ((wrEn || wrCommit) && !wrOn) || ((rdEn || rdRelease) && !rdOn);
  end

  logic [NUM_EP-1:0] fillHalfV, drainHalfV, wrOkV, rdOkV;
  logic [CntW-1:0]   fillCntA  [NUM_EP];
  logic [CntW-1:0]   rdPtrA    [NUM_EP];
  logic [CntW-1:0]   drainLenA [NUM_EP];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_slot
    logic wrSel, rdSel, clrSel;
    assign wrSel  = wrOn && (wrEp == EpW'(e));
    assign rdSel  = rdOn && (rdEp == EpW'(e));
    assign clrSel = cfgWr && cfgOk && (cfgEp == EpW'(e));

    epbuf_slot u_slot (
      .clk       (clk),
      .rstN      (rstN),
      .clr       (clrSel),
      .maxPkt    (epMax[e]),
      .dbl       (epDbl[e]),
      .wrReq     (wrSel && wrEn && !wrCommit),
      .commitReq (wrSel && wrCommit),
      .rdReq     (rdSel && rdEn && !rdRelease),
      .releaseReq(rdSel && rdRelease),
      .fillHalf  (fillHalfV[e]),
      .drainHalf (drainHalfV[e]),
      .fillCnt   (fillCntA[e]),
      .rdPtr     (rdPtrA[e]),
      .drainLen  (drainLenA[e]),
      .wrOk      (wrOkV[e]),
      .rdOk      (rdOkV[e]),
      .full      (epFull[e]),
      .overflow  (overflow[e]),
      .underflow (underflow[e]),
      .pktDone   (pktDone[e])
    );
  end

  function automatic logic [AddrW-1:0] halfBase(input logic [AddrW-1:0] base,
                                                input logic [SizeW-1:0] size,
                                                input logic half);
    return base + (half ? AddrW'(size >> 1) : '0);
  endfunction

  always_comb begin
    stb.wrStb  = |wrOkV;
    stb.wrAddr = halfBase(epBase[wrEp], epSize[wrEp], fillHalfV[wrEp]) + AddrW'(fillCntA[wrEp]);
    stb.wrByte = wrData;
    stb.rdStb  = |rdOkV;
    stb.rdAddr = halfBase(epBase[rdEp], epSize[rdEp], drainHalfV[rdEp]) + AddrW'(rdPtrA[rdEp]);
  end

  assign rdLen = drainLenA[rdEp];
endmodule

// File: rtl/epbuf_dp.sv
module epbuf_dp
  import epbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       stb,
  output logic [DataW-1:0] rdData
);
  logic [DataW-1:0] mem [RamBytes];

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[stb.wrAddr] <= stb.wrByte;
  end

  // a refused or empty read yields zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[stb.rdAddr];
    else                rdData <= '0;
  end
endmodule

// File: rtl/ep_packet_buffer.sv
module ep_packet_buffer
  import epbuf_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned EpW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [EpW-1:0]    cfgEp,
  input  logic [AddrW-1:0]  cfgBase,
  input  logic [SizeW-1:0]  cfgSize,
  input  logic [CntW-1:0]   cfgMaxPkt,
  input  logic              cfgDouble,
  output logic              cfgAck,
  output logic [ErrW-1:0]   cfgErr,
  input  logic              wrEn,
  input  logic              wrCommit,
  input  logic [EpW-1:0]    wrEp,
  input  logic [DataW-1:0]  wrData,
  input  logic              rdEn,
  input  logic              rdRelease,
  input  logic [EpW-1:0]    rdEp,
  output logic [DataW-1:0]  rdData,
  output logic [CntW-1:0]   rdLen,
  output logic [NUM_EP-1:0] epFull,
  output logic [NUM_EP-1:0] pktDone,
  output logic [NUM_EP-1:0] overflow,
  output logic [NUM_EP-1:0] underflow,
  output logic              reject
);
  dp_strobe_t stb;

  epbuf_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgEp(cfgEp), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgMaxPkt(cfgMaxPkt), .cfgDouble(cfgDouble), .cfgAck(cfgAck), .cfgErr(cfgErr),
    .wrEn(wrEn), .wrCommit(wrCommit), .wrEp(wrEp), .wrData(wrData),
    .rdEn(rdEn), .rdRelease(rdRelease), .rdEp(rdEp), .rdLen(rdLen),
    .epFull(epFull), .pktDone(pktDone), .overflow(overflow), .underflow(underflow),
    .reject(reject), .stb(stb)
  );

  epbuf_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData)
  );
endmodule

// File: rtl/epbuf_chk.sv
module epbuf_chk
  import epbuf_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned EpW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic [EpW-1:0]    cfgEp,
  input logic              cfgAck,
  input logic [ErrW-1:0]   cfgErr,
  input logic              wrEn,
  input logic              wrCommit,
  input logic              rdEn,
  input logic              rdRelease,
  input logic [DataW-1:0]  rdData,
  input logic [NUM_EP-1:0] pktDone,
  input logic [NUM_EP-1:0] overflow,
  input logic [NUM_EP-1:0] underflow,
  input logic              reject
);
  p_cfg_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> $past(cfgWr));

  p_ep0_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgEp == '0) |=> (cfgAck && cfgErr[4]));

  p_reject_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> $past(wrEn || wrCommit || rdEn || rdRelease));

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|pktDone) |-> $past(wrCommit));

  p_done_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pktDone));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWr) |-> (($past(overflow) & ~overflow) == '0));

  p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWr) |-> (($past(underflow) & ~underflow) == '0));

  p_rd_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != '0) |-> $past(rdEn && !rdRelease));
endmodule

bind ep_packet_buffer epbuf_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEp(cfgEp), .cfgAck(cfgAck),
  .cfgErr(cfgErr), .wrEn(wrEn), .wrCommit(wrCommit), .rdEn(rdEn),
  .rdRelease(rdRelease), .rdData(rdData), .pktDone(pktDone),
  .overflow(overflow), .underflow(underflow), .reject(reject)
);

// File: tb/ep_packet_buffer_tb.sv
module ep_packet_buffer_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr, cfgDouble, wrEn, wrCommit, rdEn, rdRelease;
  logic [1:0]  cfgEp, wrEp, rdEp;
  logic [11:0] cfgBase;
  logic [12:0] cfgSize;
  logic [6:0]  cfgMaxPkt, rdLen;
  logic        cfgAck, reject;
  logic [4:0]  cfgErr;
  logic [7:0]  wrData, rdData;
  logic [3:0]  epFull, pktDone, overflow, underflow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ep_packet_buffer u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgEp(cfgEp), .cfgBase(cfgBase),
    .cfgSize(cfgSize), .cfgMaxPkt(cfgMaxPkt), .cfgDouble(cfgDouble),
    .cfgAck(cfgAck), .cfgErr(cfgErr), .wrEn(wrEn), .wrCommit(wrCommit),
    .wrEp(wrEp), .wrData(wrData), .rdEn(rdEn), .rdRelease(rdRelease),
    .rdEp(rdEp), .rdData(rdData), .rdLen(rdLen), .epFull(epFull),
    .pktDone(pktDone), .overflow(overflow), .underflow(underflow), .reject(reject)
  );

  // {ep, base, size, maxPkt, double, expected cfgErr}
  typedef struct packed {
    logic [1:0] ep; logic [11:0] base; logic [12:0] size;
    logic [6:0] mp; logic dbl; logic [4:0] err;
  } cfg_vec_t;
  localparam int NumVec = 12;
  localparam logic [39:0] CfgVec [NumVec] = '{
    {2'd0, 12'd64,   13'd64,  7'd64, 1'b0, 5'h10},
    {2'd1, 12'd64,   13'd32,  7'd64, 1'b0, 5'h01},
    {2'd1, 12'd68,   13'd128, 7'd64, 1'b1, 5'h08},
    {2'd1, 12'd32,   13'd64,  7'd64, 1'b0, 5'h02},
    {2'd1, 12'd4064, 13'd64,  7'd32, 1'b0, 5'h04},
    {2'd1, 12'd64,   13'd128, 7'd64, 1'b1, 5'h00},
    {2'd2, 12'd192,  13'd64,  7'd64, 1'b1, 5'h01},
    {2'd2, 12'd184,  13'd64,  7'd64, 1'b0, 5'h02},
    {2'd2, 12'd192,  13'd64,  7'd64, 1'b0, 5'h00},
    {2'd3, 12'd256,  13'd16,  7'd8,  1'b1, 5'h00},
    {2'd3, 12'd512,  13'd64,  7'd0,  1'b0, 5'h01},
    {2'd3, 12'd4032, 13'd64,  7'd65, 1'b0, 5'h01}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doCfg(input logic [1:0] ep, input logic [11:0] base, input logic [12:0] size,
                       input logic [6:0] mp, input logic dbl);
    @(negedge clk);
    cfgEp = ep; cfgBase = base; cfgSize = size; cfgMaxPkt = mp; cfgDouble = dbl; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic wrByte(input logic [1:0] ep, input logic [7:0] d);
    @(negedge clk);
    wrEp = ep; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic commitPkt(input logic [1:0] ep);
    @(negedge clk);
    wrEp = ep; wrCommit = 1'b1;
    @(negedge clk);
    wrCommit = 1'b0;
  endtask

  task automatic rdByte(input logic [1:0] ep, output logic [7:0] d);
    @(negedge clk);
    rdEp = ep; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic relPkt(input logic [1:0] ep);
    @(negedge clk);
    rdEp = ep; rdRelease = 1'b1;
    @(negedge clk);
    rdRelease = 1'b0;
  endtask

  task automatic lenOf(input logic [1:0] ep, output logic [6:0] n);
    @(negedge clk);
    rdEp = ep;
    #1 n = rdLen;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [6:0] n;
    int bad;
    rstN = 1'b0; cfgWr = 0; cfgEp = 0; cfgBase = 0; cfgSize = 0; cfgMaxPkt = 0; cfgDouble = 0;
    wrEn = 0; wrCommit = 0; wrEp = 0; wrData = 0; rdEn = 0; rdRelease = 0; rdEp = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 epFull", 32'(epFull), 0);
    chk("R1 pktDone", 32'(pktDone), 0);
    chk("R1 flags", 32'({overflow, underflow}), 0);
    chk("R1 reject/cfgAck", 32'({reject, cfgAck}), 0);
    chk("R1 rdData", 32'(rdData), 0);

    // unconfigured endpoint traffic
    wrByte(2'd2, 8'h55);
    chk("R4 write reject", 32'(reject), 1);
    rdByte(2'd2, d);
    chk("R4 read reject", 32'(reject), 1);
    chk("R4 no underflow", 32'(underflow), 0);
    chk("R4 no data", 32'(d), 0);

    // table walk of region requests
    for (int i = 0; i < NumVec; i++) begin
      cfg_vec_t v;
      v = cfg_vec_t'(CfgVec[i]);
      doCfg(v.ep, v.base, v.size, v.mp, v.dbl);
      chk((v.ep == 2'd0) ? "R2 ep0 request" : "R3 cfgErr", 32'({cfgAck, cfgErr}), 32'({1'b1, v.err}));
    end

    // endpoint 0, single-buffered
    wrByte(2'd0, 8'h11);
    wrByte(2'd0, 8'h22);
    wrByte(2'd0, 8'h33);
    commitPkt(2'd0);
    chk("R5 pktDone ep0", 32'(pktDone), 32'h1);
    chk("R6 single full", 32'(epFull[0]), 1);
    wrByte(2'd0, 8'h44);
    commitPkt(2'd0);
    chk("R7 stalled commit", 32'(pktDone), 0);
    lenOf(2'd0, n);
    chk("R7 stalled write not counted", 32'(n), 3);
    rdByte(2'd0, d); chk("R9 byte0", 32'(d), 32'h11);
    rdByte(2'd0, d); chk("R9 byte1", 32'(d), 32'h22);
    rdByte(2'd0, d); chk("R9 byte2", 32'(d), 32'h33);
    rdByte(2'd0, d);
    chk("R10 past end data", 32'(d), 0);
    chk("R10 underflow ep0", 32'(underflow), 32'h1);
    relPkt(2'd0);
    chk("R11 ep0 freed", 32'(epFull[0]), 0);
    lenOf(2'd0, n);
    chk("R11 ep0 empty", 32'(n), 0);

    // endpoint 1, double-buffered, 64-byte limit
    for (int i = 0; i < 64; i++) wrByte(2'd1, 8'(i + 1));
    chk("R8 no overflow at limit", 32'(overflow[1]), 0);
    wrByte(2'd1, 8'hEE);
    chk("R8 overflow set", 32'(overflow[1]), 1);
    commitPkt(2'd1);
    chk("R5 pktDone ep1", 32'(pktDone), 32'h2);
    chk("R6 one half free", 32'(epFull[1]), 0);
    wrByte(2'd1, 8'hA0);
    wrByte(2'd1, 8'hA1);
    commitPkt(2'd1);
    chk("R6 both halves full", 32'(epFull[1]), 1);
    wrByte(2'd1, 8'hBB);
    lenOf(2'd1, n);
    chk("R9 rdLen first packet", 32'(n), 64);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rdByte(2'd1, d);
      if (d !== 8'(i + 1)) bad++;
    end
    chk("R9 64-byte packet order", 32'(bad), 0);
    relPkt(2'd1);
    chk("R11 ep1 half freed", 32'(epFull[1]), 0);
    lenOf(2'd1, n);
    chk("R7 stalled byte dropped", 32'(n), 2);
    rdByte(2'd1, d);
    chk("R11 second half drained", 32'(d), 32'hA0);
    chk("R8 overflow sticky", 32'(overflow[1]), 1);

    // isolation between endpoints 2 and 3
    wrByte(2'd2, 8'h5A);
    commitPkt(2'd2);
    wrByte(2'd3, 8'hC3);
    commitPkt(2'd3);
    rdByte(2'd2, d); chk("R13 ep2 data", 32'(d), 32'h5A);
    rdByte(2'd3, d); chk("R13 ep3 data", 32'(d), 32'hC3);
    rdByte(2'd2, d);
    chk("R10 ep2 empty read", 32'({underflow[2], d}), 32'h100);
    commitPkt(2'd2);
    chk("R7 single stalled commit", 32'(pktDone), 0);

    // ep3 kept its 8-byte limit after refused requests
    for (int i = 0; i < 9; i++) wrByte(2'd3, 8'h70 + 8'(i));
    chk("R3 refused keeps old limit", 32'(overflow[3]), 1);
    doCfg(2'd3, 12'd256, 13'd16, 7'd8, 1'b1);
    chk("R12 reconfig accepted", 32'({cfgAck, cfgErr}), 32'h20);
    chk("R12 full cleared", 32'(epFull[3]), 0);
    chk("R12 overflow cleared", 32'(overflow[3]), 0);
    lenOf(2'd3, n);
    chk("R12 buffer cleared", 32'(n), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule